// File: doc/BRIEF.md
# Serial Sticky Digit Accumulator

This block forms the sticky indication for a digit-serial decimal multiplier. The multiplier emits the low-order digits of its product one per cycle. Every digit that will end up below the round position after normalisation must be folded into one sticky flag. The block does this as the digits go by, rather than OR-reducing a wide shifted product at the end.

A load strobe gives the block the leading-zero counts of the two operand significands, each between 0 and P. From these it prepares a count of the digits that fall below the round digit: `P - 2 - (lzA + lzB)`. The 2 accounts for the guard and round digits, and a negative result is treated as zero. Preparing the count takes two cycles. After that, each valid BCD digit is consumed while the count is positive: its nonzero status is ORed into the sticky flag and the count drops by one. When the count reaches zero, a done flag rises and the sticky value is final.

Top module: `sticky_digit_acc`

## Requirements
- R1: While reset is asserted and after it is released, `sticky` and `done` read 0 until a consumed digit or a finished count changes them.
- R2: A load sampled on a clock edge restarts the block from any state and has priority over digit input: `sticky` and `done` both read 0 in the following cycle.
- R3: The number of digits consumed after a load is `P - 2 - (lzA + lzB)`, or zero when that value is negative. `done` rises in the cycle after the last such digit is consumed, or as soon as the count is ready when it is zero.
- R4: Digits sampled on the two clock edges that follow the load edge are ignored while the count is prepared. The count is ready, and digits are consumed, from the third edge after the load onward.
- R5: A consumed digit whose 4-bit value is nonzero (any bit set) sets `sticky`. A consumed digit of 0 decrements the count without setting it. Once set, `sticky` stays at 1 until the next load.
- R6: A digit presented with `digValid` low is not consumed: the count does not change and `sticky` is not affected.
- R7: Once `done` is 1, further digits are ignored and the count does not go below zero. `done` and `sticky` hold their values until the next load.
- R8: `lzA` and `lzB` are each in the range 0 to P, where P = 16 by default. Their sum may exceed P - 2, and this yields a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start a new product; samples lzA and lzB |
| lzA | input | $clog2(P+1) | Leading-zero digit count of the first operand |
| lzB | input | $clog2(P+1) | Leading-zero digit count of the second operand |
| digValid | input | 1 | The digit input carries a product digit this cycle |
| digit | input | 4 | Low-order product digit, BCD |
| sticky | output | 1 | OR of the nonzero status of all consumed digits |
| done | output | 1 | All sticky digits have been consumed |

## Verification
The assertions assume that the leading-zero counts never exceed P when a load is sampled. They also assume that a rising `sticky` is always caused by a valid nonzero digit on the preceding edge. The stimulus keeps to the first assumption by drawing both counts from 0 to P only. Directed cases cover the clamped count, a count of exactly zero, nonzero digits inside the two preparation cycles, and a reload in the middle of a run. A random phase then mixes loads at arbitrary points with gaps in `digValid`, and a behavioural model is compared against the outputs on every clock.

// File: rtl/sticky_acc_pkg.sv
package sticky_acc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PREP1 = 2'd1,
    PH_PREP2 = 2'd2,
    PH_RUN   = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;    // restart: capture lz sum, clear flag and count
    logic latchDiff;   // first preparation step: signed difference
    logic latchCount;  // second preparation step: clamp into counter
    logic consume;     // fold one digit and decrement
  } ctlStrobes_t;

endpackage

// File: rtl/sticky_acc_ctl.sv
module sticky_acc_ctl
  import sticky_acc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        digValid,
  input  logic        countZero,
  output ctlStrobes_t stb,
  output logic        done
);

  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    if (load) begin
      phaseNext = PH_PREP1;
    end else begin
      unique case (phase)
        PH_IDLE:  phaseNext = PH_IDLE;
        PH_PREP1: phaseNext = PH_PREP2;
        PH_PREP2: phaseNext = PH_RUN;
        PH_RUN:   phaseNext = PH_RUN;
        default:  phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phaseNext;
  end

  always_comb begin
    stb.clearAll   = load;
    stb.latchDiff  = !load && (phase == PH_PREP1);
    stb.latchCount = !load && (phase == PH_PREP2);
    stb.consume    = !load && (phase == PH_RUN) && digValid && !countZero;
  end

  assign done = (phase == PH_RUN) && countZero;

endmodule

// File: rtl/sticky_acc_dp.sv
module sticky_acc_dp
  import sticky_acc_pkg::*;
#(
  parameter int P = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctlStrobes_t                stb,
  input  logic [$clog2(P+1)-1:0]     lzA,
  input  logic [$clog2(P+1)-1:0]     lzB,
  input  logic [3:0]                 digit,
  output logic                       countZero,
  output logic                       sticky
);

  localparam int LZW = $clog2(P+1);
  localparam int SW  = LZW + 1;     // width of lzA + lzB
  localparam int DW  = SW + 1;      // signed difference width
  localparam int CW  = $clog2(P+1); // holds up to P-2
  localparam logic signed [DW-1:0] SPAN = DW'(P - 2);

  logic [SW-1:0]        sumReg;
  logic signed [DW-1:0] diffReg;
  logic [CW-1:0]        countReg;
  logic                 stickyReg;
  logic                 digitNz;

  assign digitNz = |digit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sumReg    <= '0;
      diffReg   <= '0;
      countReg  <= '0;
      stickyReg <= 1'b0;
    end else if (stb.clearAll) begin
      sumReg    <= SW'(lzA) + SW'(lzB);
      countReg  <= '0;
      stickyReg <= 1'b0;
    end else begin
      if (stb.latchDiff)
        diffReg <= SPAN - $signed({1'b0, sumReg});
      if (stb.latchCount)
        countReg <= diffReg[DW-1] ? '0 : CW'(diffReg);
      if (stb.consume) begin
        countReg  <= countReg - 1'b1;
        stickyReg <= stickyReg | digitNz;
      end
    end
  end

  assign countZero = (countReg == '0);
  assign sticky    = stickyReg;

endmodule

// File: rtl/sticky_digit_acc.sv
module sticky_digit_acc
  import sticky_acc_pkg::*;
#(
  parameter int P = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [$clog2(P+1)-1:0] lzA,
  input  logic [$clog2(P+1)-1:0] lzB,
  input  logic                   digValid,
  input  logic [3:0]             digit,
  output logic                   sticky,
  output logic                   done
);

  ctlStrobes_t stb;
  logic        countZero;

  sticky_acc_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .digValid  (digValid),
    .countZero (countZero),
    .stb       (stb),
    .done      (done)
  );

  sticky_acc_dp #(.P(P)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .lzA       (lzA),
    .lzB       (lzB),
    .digit     (digit),
    .countZero (countZero),
    .sticky    (sticky)
  );

endmodule

// File: rtl/sticky_digit_acc_chk.sv
module sticky_digit_acc_chk #(
  parameter int P = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load,
  input logic [$clog2(P+1)-1:0] lzA,
  input logic [$clog2(P+1)-1:0] lzB,
  input logic                   digValid,
  input logic [3:0]             digit,
  input logic                   sticky,
  input logic                   done
);

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!sticky && !done)); // R2

  AST_PREP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load ##1 !load |=> (!sticky && !done)); // R4

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !load) |=> sticky); // R5

  AST_STICKY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky) |-> $past(digValid && (digit != 4'd0))); // R6

  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (done && $stable(sticky))); // R7

  AST_LZ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((int'(lzA) <= P) && (int'(lzB) <= P))); // R8

endmodule

bind sticky_digit_acc sticky_digit_acc_chk #(.P(P)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load     (load),
  .lzA      (lzA),
  .lzB      (lzB),
  .digValid (digValid),
  .digit    (digit),
  .sticky   (sticky),
  .done     (done)
);

// File: tb/sticky_digit_acc_bench.sv
`timescale 1ns/1ps
module sticky_digit_acc_bench;
  localparam int P  = 16;
  localparam int LZW = $clog2(P+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [LZW-1:0] lzA = '0, lzB = '0;
  logic digValid = 1'b0;
  logic [3:0] digit = '0;
  logic sticky, done;

  int nChecks = 0, nFails = 0;
  bit running = 1'b0;

  always #5 clk = ~clk;

  sticky_digit_acc #(.P(P)) u_sticky_digit_acc (
    .clk(clk), .rst_n(rst_n), .load(load), .lzA(lzA), .lzB(lzB),
    .digValid(digValid), .digit(digit), .sticky(sticky), .done(done)
  );

  // behavioural reference: phase number, remaining digits, flag
  int  mPhase, mLeft, mPending;
  bit  mSticky;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPhase = 0; mLeft = 0; mPending = 0; mSticky = 0;
    end else if (load) begin
      mPhase = 1; mLeft = 0; mSticky = 0;
      mPending = (P - 2) - (int'(lzA) + int'(lzB));
    end else if (mPhase == 1) begin
      mPhase = 2;
    end else if (mPhase == 2) begin
      mPhase = 3;
      mLeft = (mPending < 0) ? 0 : mPending;
    end else if (mPhase == 3 && digValid && mLeft > 0) begin
      mLeft = mLeft - 1;
      if (digit != 4'd0) mSticky = 1;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (running && rst_n) begin
      check("R5", "model sticky", sticky, mSticky);
      check("R3", "model done", done, (mPhase == 3) && (mLeft == 0));
    end
  end

  task automatic doLoad(input int a, input int b);
    load = 1'b1; lzA = LZW'(a); lzB = LZW'(b); digValid = 1'b0;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic sendDig(input bit v, input int d);
    digValid = v; digit = 4'(d);
    @(negedge clk);
    digValid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "sticky in reset", sticky, 1'b0);
    check("R1", "done in reset", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sticky after reset", sticky, 1'b0);
    check("R1", "done after reset", done, 1'b0);
    running = 1'b1;

    // count 16-2-7 = 7
    doLoad(3, 4);
    check("R2", "sticky after load", sticky, 1'b0);
    check("R2", "done after load", done, 1'b0);
    sendDig(1, 5); sendDig(1, 9);
    check("R4", "prep digits ignored", sticky, 1'b0);
    sendDig(0, 9);
    check("R6", "invalid digit sticky", sticky, 1'b0);
    check("R6", "invalid digit done", done, 1'b0);
    for (int i = 0; i < 6; i++) sendDig(1, 0);
    check("R3", "done before last digit", done, 1'b0);
    sendDig(1, 0);
    check("R3", "done after 7 digits", done, 1'b1);
    check("R5", "zero digits leave sticky low", sticky, 1'b0);
    sendDig(1, 3);
    check("R7", "digit after done ignored", sticky, 1'b0);
    check("R7", "done holds", done, 1'b1);

    // count 10, last counted digit nonzero
    doLoad(2, 2);
    sendDig(0, 0); sendDig(0, 0);
    for (int i = 0; i < 9; i++) sendDig(1, 0);
    sendDig(1, 8);
    check("R5", "tenth digit nonzero", sticky, 1'b1);
    check("R3", "done after 10", done, 1'b1);

    // negative count clamps to zero
    doLoad(10, 8);
    sendDig(1, 1); sendDig(1, 1);
    check("R8", "clamped count done", done, 1'b1);
    sendDig(1, 7);
    check("R7", "clamped ignores digit", sticky, 1'b0);

    // sum exactly P-2 gives zero count; extreme P,P clamps
    doLoad(7, 7);
    sendDig(0, 0); sendDig(0, 0);
    check("R3", "zero count done", done, 1'b1);
    doLoad(P, P);
    sendDig(0, 0); sendDig(0, 0);
    check("R8", "max lz clamp", done, 1'b1);

    // reload mid-run
    doLoad(0, 0);
    sendDig(0, 0); sendDig(0, 0);
    sendDig(1, 2);
    check("R5", "sticky set mid-run", sticky, 1'b1);
    doLoad(1, 1);
    check("R2", "reload clears sticky", sticky, 1'b0);

    // random traffic, compared by the model each clock
    for (int n = 0; n < 400; n++) begin
      doLoad($urandom_range(0, P), $urandom_range(0, P));
      for (int k = 0; k < $urandom_range(2, 22); k++)
        sendDig($urandom_range(0, 3) != 0, ($urandom_range(0, 4) == 0) ? $urandom_range(1, 9) : 0);
    end

    running = 1'b0;
    summary();
  end

endmodule